// File: doc/BRIEF.md
# Low-power SDRAM initialization sequencer

This block sits on the controller side of a low-power SDRAM and takes the memory from an unconfigured state to a usable one. After reset it holds the command bus at NOP with the clock enable high for a 200 µs settling window. It then issues a fixed series of commands: a precharge of all banks, a programmable number of auto refreshes (never fewer than eight), a write of the mode register, and a write of the extended mode register. The spacing between commands comes from counters sized from the clock period and from the row precharge, row cycle and mode-register write times. The mode and extended mode values are taken from input ports when the write is issued. A `ready` output then marks the hand-off point.

The block also moves the memory into and out of deep power-down. An entry request closes every bank, waits out the precharge time, and issues the deep power-down command with the clock enable dropped. The clock enable then stays low until an exit request arrives. Array contents are lost in that mode, so an exit raises the clock enable and replays the whole start-up series, including the 200 µs NOP window. An entry request that arrives before `ready` is held and acted on as soon as `ready` asserts.

States, in order: `S_PWR_WAIT` (settling NOP) → `S_PREALL` → `S_WAIT_RP` → `S_REF` ⇄ `S_WAIT_RC` (repeated per refresh) → `S_MRS` → `S_WAIT_MRD` → `S_EMRS` → `S_WAIT_EMRD` → `S_READY`. The entry path runs `S_READY` → `S_DPD_PRE` → `S_DPD_WRP` → `S_DPD_ENTRY` → `S_DPD_HOLD`, and an exit request returns `S_DPD_HOLD` → `S_PWR_WAIT`. Command pins use (cs_n, ras_n, cas_n, we_n): NOP = 0111, precharge = 0010, auto refresh = 0001, mode write = 0000, deep power-down = 0110, deselect = 1111.

Top module: `lpsdram_boot_seq`

## Requirements
- R1: While reset is applied, and from reset release until the clock edge numbered STARTUP_CK (25000 at 8 ns period, i.e. 200 µs), the outputs are NOP (0111) with `sd_cke` high and `ready` low; edges are counted from reset release.
- R2: The first command is a precharge-all at edge STARTUP_CK: code 0010, `sd_addr[10]` high, every other address bit zero, `sd_ba` = 00, `sd_cke` high.
- R3: The first auto refresh (code 0001, address and bank zero) is issued RP_CK = 3 cycles after the precharge-all.
- R4: The number of auto refreshes is the larger of `num_refresh` and 8, with `num_refresh` sampled at the precharge-all cycle; refreshes are RC_CK = 9 cycles apart; the mode write follows the last refresh after RC_CK cycles.
- R5: The mode write has code 0000, `sd_ba` = 00, `sd_addr[6:0]` = `mode_word`, and address bits 11:7 zero.
- R6: The extended mode write follows the mode write after MRD_CK = 2 cycles, with code 0000, `sd_ba` = 10 (bit 1 set), `sd_addr[4:0]` = `ext_word`, and address bits 11:5 zero. Bits 4:3 of `ext_word` select the self-refresh temperature range and bits 2:0 select the refreshed array portion.
- R7: `ready` rises MRD_CK cycles after the extended mode write and stays high, with NOP on the pins, until a deep power-down entry begins; every cycle between listed commands is NOP.
- R8: A one-cycle `dpd_enter_req` while `ready` is high gives a precharge-all in the next cycle, with `ready` low from that cycle on. The deep power-down command (code 0110, `sd_cke` low) follows RP_CK cycles later.
- R9: A `dpd_enter_req` pulse that arrives before `ready` is remembered. `ready` is then high for exactly one cycle, and the precharge-all of R8 follows in the next cycle.
- R10: In deep power-down, `sd_cke` stays low and the pins show deselect (1111) until `dpd_exit_req`. In the cycle after the request, `sd_cke` is high with NOP on the pins, and the R1–R7 series replays with the precharge-all STARTUP_CK cycles after that cycle.
- R11: `dpd_exit_req` outside deep power-down has no effect: `ready` stays high with NOP on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| num_refresh | input | 5 | Requested auto refresh count (minimum 8 applied) |
| mode_word | input | 7 | Mode register value: burst length, burst type, CAS latency |
| ext_word | input | 5 | Extended mode value: temperature range [4:3], array portion [2:0] |
| dpd_enter_req | input | 1 | One-cycle request to enter deep power-down |
| dpd_exit_req | input | 1 | One-cycle request to leave deep power-down |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| ready | output | 1 | Memory initialized and idle |

## Verification
The hardest case to reach is an entry request that lands in the middle of initialization, because it has to survive many cycles of refresh spacing and then act in the one cycle where `ready` is high. The stimulus first goes through a full deep power-down and wake-up, so the replayed sequence runs with a new refresh count and new register words. The entry pulse is then fired during the refresh phase of that replay. A scoreboard predicts every non-NOP command with its exact cycle. Separate checks cover the one-cycle `ready` window and the clock enable level during and after power-down.

// File: rtl/lpboot_pkg.sv
package lpboot_pkg;

    typedef enum logic [3:0] {
        S_PWR_WAIT,
        S_PREALL,
        S_WAIT_RP,
        S_REF,
        S_WAIT_RC,
        S_MRS,
        S_WAIT_MRD,
        S_EMRS,
        S_WAIT_EMRD,
        S_READY,
        S_DPD_PRE,
        S_DPD_WRP,
        S_DPD_ENTRY,
        S_DPD_HOLD
    } boot_state_t;

    typedef enum logic [2:0] {
        C_NOP,
        C_HOLD_OFF,
        C_PREALL,
        C_REFRESH,
        C_MODE,
        C_EXTMODE,
        C_DPD
    } pin_cmd_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least(int unsigned val, int unsigned floor_v);
        return (val < floor_v) ? floor_v : val;
    endfunction

    function automatic cmd_pins_t pins_of(pin_cmd_t c);
        cmd_pins_t p;
        unique case (c)
            C_NOP:      p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            C_HOLD_OFF: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            C_PREALL:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            C_REFRESH:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            C_MODE:     p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            C_EXTMODE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            C_DPD:      p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
            default:    p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lpboot_timer.sv
module lpboot_timer #(
    parameter int unsigned CNT_W     = 15,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // r3: a new gap may only be armed once the previous one has run out
    p_load_after_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

endmodule

// File: rtl/lpboot_refcnt.sv
module lpboot_refcnt #(
    parameter int unsigned RC_W    = 5,
    parameter int unsigned MIN_REF = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [RC_W-1:0] req_count,
    input  logic            dec,
    output logic            none_left
);

    localparam logic [RC_W-1:0] FLOOR = RC_W'(MIN_REF);

    logic [RC_W-1:0] left_q;
    logic [RC_W-1:0] target;

    always_comb begin
        target = (req_count < FLOOR) ? FLOOR : req_count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= target;
        end else if (dec) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign none_left = (left_q == '0);

    // r4: a refresh is never issued once the quota is used up
    p_ref_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (left_q != '0));

    // r4: the quota is loaded no lower than the floor
    p_ref_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (left_q >= FLOOR));

endmodule

// File: rtl/lpboot_cmd_enc.sv
module lpboot_cmd_enc
    import lpboot_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned MODE_W = 7,
    parameter int unsigned EXT_W  = 5,
    parameter int unsigned AP_BIT = 10
) (
    input  pin_cmd_t          cmd,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [EXT_W-1:0]  ext_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [BA_W-1:0] BA_EXT = BA_W'(2);

    cmd_pins_t pins;

    always_comb begin
        pins = pins_of(cmd);
        cs_n  = pins.cs_n;
        ras_n = pins.ras_n;
        cas_n = pins.cas_n;
        we_n  = pins.we_n;
        cke   = !(cmd == C_DPD || cmd == C_HOLD_OFF);
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            C_PREALL:  addr[AP_BIT] = 1'b1;
            C_MODE:    addr[MODE_W-1:0] = mode_word;
            C_EXTMODE: begin
                ba = BA_EXT;
                addr[EXT_W-1:0] = ext_word;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lpsdram_boot_seq.sv
module lpsdram_boot_seq
    import lpboot_pkg::*;
#(
    parameter int unsigned CLK_PS        = 8000,
    parameter int unsigned T_STARTUP_NS  = 200000,
    parameter int unsigned T_RP_NS       = 20,
    parameter int unsigned T_RC_NS       = 70,
    parameter int unsigned T_MRD_CK      = 2,
    parameter int unsigned MIN_REF       = 8,
    parameter int unsigned RC_W          = 5,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned MODE_W        = 7,
    parameter int unsigned EXT_W         = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RC_W-1:0]   num_refresh,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [EXT_W-1:0]  ext_word,
    input  logic              dpd_enter_req,
    input  logic              dpd_exit_req,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              ready
);

    // cycle counts; every gap is at least two cycles (command + one wait)
    localparam int unsigned STARTUP_CK = at_least(ceil_div(T_STARTUP_NS * 1000, CLK_PS), 2);
    localparam int unsigned RP_CK      = at_least(ceil_div(T_RP_NS * 1000, CLK_PS), 2);
    localparam int unsigned RC_CK      = at_least(ceil_div(T_RC_NS * 1000, CLK_PS), 2);
    localparam int unsigned MRD_CK     = at_least(T_MRD_CK, 2);
    localparam int unsigned CNT_W      = $clog2(STARTUP_CK + RC_CK + RP_CK + MRD_CK);
    localparam logic [CNT_W-1:0] LD_STARTUP = CNT_W'(STARTUP_CK - 1);
    localparam logic [CNT_W-1:0] LD_RP      = CNT_W'(RP_CK - 2);
    localparam logic [CNT_W-1:0] LD_RC      = CNT_W'(RC_CK - 2);
    localparam logic [CNT_W-1:0] LD_MRD     = CNT_W'(MRD_CK - 2);
    localparam int unsigned AP_BIT     = 10;

    boot_state_t      state_q, state_d;
    pin_cmd_t         cmd;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             ref_none_left;
    logic             enter_pend_q;
    logic             enter_now;

    lpboot_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (STARTUP_CK - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lpboot_refcnt #(
        .RC_W    (RC_W),
        .MIN_REF (MIN_REF)
    ) u_refcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == S_PREALL),
        .req_count (num_refresh),
        .dec       (state_q == S_REF),
        .none_left (ref_none_left)
    );

    lpboot_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .MODE_W (MODE_W),
        .EXT_W  (EXT_W),
        .AP_BIT (AP_BIT)
    ) u_enc (
        .cmd       (cmd),
        .mode_word (mode_word),
        .ext_word  (ext_word),
        .cke       (sd_cke),
        .cs_n      (sd_cs_n),
        .ras_n     (sd_ras_n),
        .cas_n     (sd_cas_n),
        .we_n      (sd_we_n),
        .ba        (sd_ba),
        .addr      (sd_addr)
    );

    // a request seen before ready is remembered until ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enter_pend_q <= 1'b0;
        end else if (state_q == S_READY) begin
            enter_pend_q <= 1'b0;
        end else if (dpd_enter_req) begin
            enter_pend_q <= 1'b1;
        end
    end

    assign enter_now = dpd_enter_req || enter_pend_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_PWR_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and timer arming
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_PWR_WAIT:  if (tmr_expired) state_d = S_PREALL;
            S_PREALL: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
                state_d  = S_WAIT_RP;
            end
            S_WAIT_RP:   if (tmr_expired) state_d = S_REF;
            S_REF: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RC;
                state_d  = S_WAIT_RC;
            end
            S_WAIT_RC: begin
                if (tmr_expired) state_d = ref_none_left ? S_MRS : S_REF;
            end
            S_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
                state_d  = S_WAIT_MRD;
            end
            S_WAIT_MRD:  if (tmr_expired) state_d = S_EMRS;
            S_EMRS: begin
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
                state_d  = S_WAIT_EMRD;
            end
            S_WAIT_EMRD: if (tmr_expired) state_d = S_READY;
            S_READY:     if (enter_now) state_d = S_DPD_PRE;
            S_DPD_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
                state_d  = S_DPD_WRP;
            end
            S_DPD_WRP:   if (tmr_expired) state_d = S_DPD_ENTRY;
            S_DPD_ENTRY: state_d = S_DPD_HOLD;
            S_DPD_HOLD: begin
                if (dpd_exit_req) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_STARTUP;
                    state_d  = S_PWR_WAIT;
                end
            end
            default:     state_d = S_PWR_WAIT;
        endcase
    end

    // outputs from state
    always_comb begin
        ready = 1'b0;
        unique case (state_q)
            S_PREALL, S_DPD_PRE: cmd = C_PREALL;
            S_REF:               cmd = C_REFRESH;
            S_MRS:               cmd = C_MODE;
            S_EMRS:              cmd = C_EXTMODE;
            S_DPD_ENTRY:         cmd = C_DPD;
            S_DPD_HOLD:          cmd = C_HOLD_OFF;
            S_READY: begin
                cmd   = C_NOP;
                ready = 1'b1;
            end
            default:             cmd = C_NOP;
        endcase
    end

    // r2: a precharge on the pins always closes every bank
    p_preall_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010) |-> (sd_addr[AP_BIT] && sd_cke));

    // r6: the extended write is always preceded by the mode-write gap
    p_emrs_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMRS) |-> ($past(state_q) == S_WAIT_MRD));

    // r7: ready coincides with an idle, clock-enabled bus
    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

    // r8: ready only drops by starting the power-down precharge
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> (state_q == S_DPD_PRE));

    // r8: the power-down command comes after the precharge wait, with CKE low
    p_dpd_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DPD_ENTRY) |-> ($past(state_q) == S_DPD_WRP && !sd_cke));

    // r10: while held down the bus is deselected with CKE low
    p_hold_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DPD_HOLD) |-> (!sd_cke && sd_cs_n));

    // r10: leaving power-down raises CKE
    p_wake_cke_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PWR_WAIT && $past(state_q) == S_DPD_HOLD) |-> (sd_cke && !$past(sd_cke)));

endmodule

// File: tb/tb_lpsdram_boot_seq.sv
`timescale 1ns/1ps
module tb_lpsdram_boot_seq;

    localparam int CK_STARTUP = 25000; // 200 us at 8 ns
    localparam int CK_RP      = 3;     // 20 ns
    localparam int CK_RC      = 9;     // 70 ns
    localparam int CK_MRD     = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  num_refresh;
    logic [6:0]  mode_word;
    logic [4:0]  ext_word;
    logic        dpd_enter_req;
    logic        dpd_exit_req;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic        ready;

    always #4 clk = ~clk;

    lpsdram_boot_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .num_refresh   (num_refresh),
        .mode_word     (mode_word),
        .ext_word      (ext_word),
        .dpd_enter_req (dpd_enter_req),
        .dpd_exit_req  (dpd_exit_req),
        .sd_cke        (sd_cke),
        .sd_cs_n       (sd_cs_n),
        .sd_ras_n      (sd_ras_n),
        .sd_cas_n      (sd_cas_n),
        .sd_we_n       (sd_we_n),
        .sd_ba         (sd_ba),
        .sd_addr       (sd_addr),
        .ready         (ready)
    );

    int n = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    int          q_cyc[$];
    logic [18:0] q_val[$];
    string       q_tag[$];

    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, what, act, exp, n);
        end
    endtask

    function automatic logic [3:0] code();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic push(input int c, input logic cke, input logic [3:0] cd,
                        input logic [1:0] ba, input logic [11:0] addr, input string tag);
        q_cyc.push_back(c);
        q_val.push_back({cke, cd, ba, addr});
        q_tag.push_back(tag);
    endtask

    // expected start-up series from precharge-all at cycle p; returns ready cycle
    task automatic push_init(input int p, input int nref, input logic [11:0] maddr,
                             input logic [11:0] eaddr, output int rdy);
        push(p, 1'b1, 4'b0010, 2'b00, 12'h400, "R2 precharge-all");
        for (int i = 0; i < nref; i++)
            push(p + CK_RP + CK_RC * i, 1'b1, 4'b0001, 2'b00, 12'h000,
                 (i == 0) ? "R3 first refresh" : "R4 refresh");
        push(p + CK_RP + CK_RC * nref, 1'b1, 4'b0000, 2'b00, maddr, "R5 mode write");
        push(p + CK_RP + CK_RC * nref + CK_MRD, 1'b1, 4'b0000, 2'b10, eaddr, "R6 ext mode write");
        rdy = p + CK_RP + CK_RC * nref + 2 * CK_MRD;
    endtask

    // monitor: every non-idle command is compared against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (code() != 4'b0111 && code() != 4'b1111) begin
                if (q_cyc.size() == 0) begin
                    chk(1'b0, "R7", "unexpected command", int'(code()), 4'b0111);
                end else begin
                    int          ec;
                    logic [18:0] ev;
                    string       et;
                    ec = q_cyc.pop_front();
                    ev = q_val.pop_front();
                    et = q_tag.pop_front();
                    chk(n == ec, et, "cycle", n, ec);
                    chk({sd_cke, code(), sd_ba, sd_addr} == ev, et, "pins",
                        int'({sd_cke, code(), sd_ba, sd_addr}), int'(ev));
                end
            end
        end
    end

    task automatic wait_to(input int x);
        while (n < x) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", n);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int r1, r2, x, y, p2;
        rst_n = 1'b0;
        num_refresh = 5'd3;       // below floor: 8 expected
        mode_word = 7'h32;
        ext_word = 5'h15;         // 15 C range, one-eighth array
        dpd_enter_req = 1'b0;
        dpd_exit_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(code() == 4'b0111 && sd_cke && !ready, "R1", "reset pins",
            int'({sd_cke, code(), ready}), 6'b101110);
        #1 rst_n = 1'b1;

        push_init(CK_STARTUP, 8, 12'h032, 12'h015, r1);
        wait_to(1);
        chk(code() == 4'b0111 && sd_cke && !ready, "R1", "early NOP",
            int'({sd_cke, code(), ready}), 6'b101110);
        wait_to(CK_STARTUP - 1);
        chk(code() == 4'b0111 && sd_cke && !ready, "R1", "last NOP",
            int'({sd_cke, code(), ready}), 6'b101110);
        wait_to(r1 - 1);
        chk(!ready, "R7", "ready before gap", ready, 0);
        wait_to(r1);
        chk(ready, "R7", "ready asserted", ready, 1);

        // exit request with no power-down in progress
        wait_to(r1 + 2);
        dpd_exit_req = 1'b1;
        wait_to(r1 + 3);
        dpd_exit_req = 1'b0;
        chk(ready && sd_cke && code() == 4'b0111, "R11", "exit ignored",
            int'({ready, sd_cke, code()}), 6'b110111);
        wait_to(r1 + 6);
        chk(ready && sd_cke && code() == 4'b0111, "R11", "still ready",
            int'({ready, sd_cke, code()}), 6'b110111);

        num_refresh = 5'd12;
        mode_word = 7'h23;
        ext_word = 5'h1B;

        // deep power-down entry from ready
        x = r1 + 10;
        wait_to(x);
        dpd_enter_req = 1'b1;
        push(x + 1, 1'b1, 4'b0010, 2'b00, 12'h400, "R8 precharge before power-down");
        push(x + 1 + CK_RP, 1'b0, 4'b0110, 2'b00, 12'h000, "R8 power-down command");
        wait_to(x + 1);
        dpd_enter_req = 1'b0;
        chk(!ready, "R8", "ready dropped", ready, 0);
        wait_to(x + 6);
        chk(!sd_cke && sd_cs_n, "R10", "held down", int'({sd_cke, sd_cs_n}), 2'b01);
        y = x + 50;
        wait_to(y);
        chk(!sd_cke && code() == 4'b1111, "R10", "still held",
            int'({sd_cke, code()}), 5'b01111);
        dpd_exit_req = 1'b1;
        wait_to(y + 1);
        dpd_exit_req = 1'b0;
        chk(sd_cke && code() == 4'b0111, "R10", "wake NOP",
            int'({sd_cke, code()}), 5'b10111);

        // replay with 12 refreshes; entry pulse arrives mid-refresh
        p2 = y + 1 + CK_STARTUP;
        push_init(p2, 12, 12'h023, 12'h01B, r2);
        push(r2 + 1, 1'b1, 4'b0010, 2'b00, 12'h400, "R9 held-off precharge");
        push(r2 + 1 + CK_RP, 1'b0, 4'b0110, 2'b00, 12'h000, "R9 held-off power-down");
        wait_to(p2 - 1);
        chk(sd_cke && code() == 4'b0111, "R10", "replay NOP",
            int'({sd_cke, code()}), 5'b10111);
        wait_to(p2 + 20);
        dpd_enter_req = 1'b1;
        wait_to(p2 + 21);
        dpd_enter_req = 1'b0;
        chk(!ready, "R9", "held off during init", ready, 0);
        wait_to(r2);
        chk(ready, "R9", "ready for one cycle", ready, 1);
        wait_to(r2 + 1);
        chk(!ready, "R9", "ready gone next cycle", ready, 0);
        wait_to(r2 + 10);
        chk(!sd_cke, "R10", "cke low after held-off entry", sd_cke, 0);
        chk(q_cyc.size() == 0, "R4", "all expected commands seen", q_cyc.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule